// File: doc/BRIEF.md
# Link Transmit Frame Sequencer

This block is the sending side of a serial link layer that works in 32-bit dwords. A client offers a frame's payload as a stream with valid, last and ready. The sequencer asks the far end for the channel and waits for permission. It then sends a start marker, the payload, a trailing CRC and an end marker. Last, it waits for the far end to report whether the frame was received intact.

Every payload dword and the CRC dword are XORed with a keystream from an LFSR before they go out. The CRC itself is computed over the unscrambled payload. While the block is sending payload, the far end can stall it with a hold primitive. The block then answers with a hold-acknowledge and takes no payload that cycle. If the client runs dry in the middle of a frame, the block sends its own hold primitive. Each transmitted dword comes with a control-lane flag that marks it as either a primitive or data.

The received-primitive input is decoded in the same cycle it arrives. All transmit outputs are registered, so a decision taken at a clock edge appears on the wire for the following cycle.

Top module: `link_tx_framer`

## Requirements
- R1: After reset, and for as long as no payload is offered while idle, the block transmits SYNC (32'hB5B5957C). The frame-done, ok and error outputs stay low. A frame request starts on the first cycle that `pl_valid_i` is high while idle.
- R2: `tx_kflag_o` is 4'b0001 with every primitive and 4'b0000 with every payload or CRC dword. The primitive codes are: X_RDY 32'h5757B57C, R_RDY 32'h4A4A957C, SOF 32'h3737B57C, EOF 32'hD5D5B57C, HOLD 32'hD5D5AA7C, HOLDA 32'h9595AA7C, R_OK 32'h3535B57C, R_ERR 32'h5656B57C, WTRM 32'h5858B57C, SYNC 32'hB5B5957C.
- R3: During the request phase, X_RDY is sent every cycle. A received R_RDY makes the next dword a single SOF, after which the payload phase begins.
- R4: In the payload phase, including the cycle just before the CRC, a received HOLD makes the next dword HOLDA. In a HOLD cycle, `pl_ready_o` is low and no payload is taken.
- R5: In the payload phase, a cycle with no HOLD received and no payload offered makes the next dword HOLD.
- R6: A taken payload dword is sent as data XOR key. A 16-bit register is seeded with 16'hFFFF when SOF is issued. Key bit i, for i from 0 to 31, is register bit 15 at that moment. After each bit, the register shifts left and takes bit15^bit14^bit12^bit3 as its new bit 0. The register advances only on dwords that carry data or CRC.
- R7: After the dword marked last, exactly one CRC dword follows, scrambled like payload. The CRC is computed over the unscrambled payload, MSB first, with polynomial 32'h04C11DB7, initial value 32'h52325032 and no final inversion.
- R8: The CRC dword is followed by exactly one EOF. After that, WTRM is sent every cycle until a verdict arrives.
- R9: A received R_OK or R_ERR during WTRM makes the next dword SYNC. In that same cycle, `frm_done_o` pulses for one cycle, together with exactly one of `frm_ok_o` (for R_OK) or `frm_err_o` (for R_ERR).
- R10: A received word counts as a primitive only when `rx_kflag_i` is exactly 4'b0001 and all 32 bits match. A primitive that does not apply to the current phase has no effect.
- R11: `pl_ready_o` is high only in the SOF or payload phase, before the last dword has been taken, and while no HOLD is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pl_data_i | input | 32 | Payload dword |
| pl_valid_i | input | 1 | Payload dword offered |
| pl_last_i | input | 1 | Offered dword is the final one of the frame |
| pl_ready_o | output | 1 | Payload dword taken this cycle when valid |
| rx_data_i | input | 32 | Dword received from the far end |
| rx_kflag_i | input | 4 | Control-lane flags of the received dword |
| tx_data_o | output | 32 | Transmitted dword |
| tx_kflag_o | output | 4 | Control-lane flags of the transmitted dword |
| frm_done_o | output | 1 | One-cycle pulse when a frame has been concluded |
| frm_ok_o | output | 1 | Frame concluded with a good verdict |
| frm_err_o | output | 1 | Frame concluded with a bad verdict |

## Verification
Two rules can compete in the same cycle. The far end's HOLD stall may land exactly when the client offers the dword marked last, and the same stall may also land on the cycle that would otherwise launch the CRC. The bench provokes both clashes with a directed one-dword frame, and a seeded random run adds many more, since HOLD, spoofed primitives and payload gaps are drawn independently every cycle. A reference model in the bench judges each cycle's outcome. The stall must win in both cases: HOLDA goes out, ready stays low, and the last dword or the CRC follows on the first cycle without a stall.

// File: rtl/txs_pkg.sv
package txs_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned KF_W   = 4;

  localparam logic [WORD_W-1:0] P_SYNC  = 32'hB5B5957C;
  localparam logic [WORD_W-1:0] P_XRDY  = 32'h5757B57C;
  localparam logic [WORD_W-1:0] P_RRDY  = 32'h4A4A957C;
  localparam logic [WORD_W-1:0] P_SOF   = 32'h3737B57C;
  localparam logic [WORD_W-1:0] P_EOF   = 32'hD5D5B57C;
  localparam logic [WORD_W-1:0] P_HOLD  = 32'hD5D5AA7C;
  localparam logic [WORD_W-1:0] P_HOLDA = 32'h9595AA7C;
  localparam logic [WORD_W-1:0] P_ROK   = 32'h3535B57C;
  localparam logic [WORD_W-1:0] P_RERR  = 32'h5656B57C;
  localparam logic [WORD_W-1:0] P_WTRM  = 32'h5858B57C;

  localparam logic [KF_W-1:0] K_PRIM = 4'b0001;
  localparam logic [KF_W-1:0] K_DATA = 4'b0000;

  // phase of the dword currently on the wire
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_SOF,
    PH_BODY,
    PH_CHK,
    PH_EOF,
    PH_TERM
  } phase_e;

  typedef struct packed {
    logic rrdy;
    logic hold;
    logic rok;
    logic rerr;
  } rx_evt_t;

endpackage

// File: rtl/txs_rxdec.sv
module txs_rxdec
  import txs_pkg::*;
(
  input  logic [WORD_W-1:0] rx_data_i,
  input  logic [KF_W-1:0]   rx_kflag_i,
  output rx_evt_t           evt_o
);

  logic is_ctrl;

  always_comb begin
    is_ctrl    = (rx_kflag_i == K_PRIM);
    evt_o.rrdy = is_ctrl && (rx_data_i == P_RRDY);
    evt_o.hold = is_ctrl && (rx_data_i == P_HOLD);
    evt_o.rok  = is_ctrl && (rx_data_i == P_ROK);
    evt_o.rerr = is_ctrl && (rx_data_i == P_RERR);
  end

endmodule

// File: rtl/txs_scrambler.sv
module txs_scrambler #(
  parameter int unsigned              WORD_W = 32,
  parameter int unsigned              LFSR_W = 16,
  parameter logic [LFSR_W-1:0]        SEED   = 16'hFFFF,
  parameter logic [LFSR_W-1:0]        TAPS   = 16'hD008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] key_o
);

  localparam int unsigned MSB = LFSR_W - 1;

  logic [LFSR_W-1:0] st_q;
  logic [LFSR_W-1:0] st_n;
  logic [LFSR_W-1:0] walk;
  logic              st_en;

  // unroll one dword worth of keystream bits
  always_comb begin
    walk = st_q;
    for (int i = 0; i < int'(WORD_W); i++) begin
      key_o[i] = walk[MSB];
      walk     = {walk[MSB-1:0], ^(walk & TAPS)};
    end
  end

  always_comb begin
    st_en = load_i || step_i;
    st_n  = load_i ? SEED : walk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
    end else if (st_en) begin
      st_q <= st_n;
    end
  end

endmodule

// File: rtl/txs_crc.sv
module txs_crc #(
  parameter int unsigned       WORD_W = 32,
  parameter int unsigned       CRC_W  = 32,
  parameter logic [CRC_W-1:0]  POLY   = 32'h04C11DB7,
  parameter logic [CRC_W-1:0]  INIT   = 32'h52325032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              upd_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);

  localparam int unsigned TOP = CRC_W - 1;

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_n;
  logic [CRC_W-1:0] acc;
  logic             fb;
  logic             crc_en;

  always_comb begin
    acc = crc_q;
    fb  = 1'b0;
    for (int b = int'(WORD_W) - 1; b >= 0; b--) begin
      fb  = acc[TOP] ^ data_i[b];
      acc = {acc[TOP-1:0], 1'b0};
      if (fb) begin
        acc = acc ^ POLY;
      end
    end
  end

  always_comb begin
    crc_en = load_i || upd_i;
    crc_n  = load_i ? INIT : acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else if (crc_en) begin
      crc_q <= crc_n;
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/txs_fsm.sv
module txs_fsm
  import txs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rx_evt_t           evt_i,
  input  logic [WORD_W-1:0] pl_data_i,
  input  logic              pl_valid_i,
  input  logic              pl_last_i,
  output logic              pl_ready_o,
  input  logic [WORD_W-1:0] key_i,
  input  logic [WORD_W-1:0] crc_i,
  output logic              scr_load_o,
  output logic              scr_step_o,
  output logic              crc_load_o,
  output logic              crc_upd_o,
  output logic [WORD_W-1:0] tx_data_o,
  output logic [KF_W-1:0]   tx_kflag_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              err_o
);

  phase_e            ph_q, ph_n;
  logic              tail_q, tail_n, tail_en;
  logic [WORD_W-1:0] word_q, word_n;
  logic [KF_W-1:0]   kf_q, kf_n;
  logic              done_q, done_n;
  logic              ok_q, ok_n;
  logic              err_q, err_n;
  logic              in_body;

  always_comb begin
    in_body    = (ph_q == PH_SOF) || (ph_q == PH_BODY);
    pl_ready_o = in_body && !tail_q && !evt_i.hold;
  end

  // next-state and next-dword decision
  always_comb begin
    ph_n       = ph_q;
    tail_n     = tail_q;
    tail_en    = 1'b0;
    word_n     = P_SYNC;
    kf_n       = K_PRIM;
    done_n     = 1'b0;
    ok_n       = 1'b0;
    err_n      = 1'b0;
    scr_load_o = 1'b0;
    scr_step_o = 1'b0;
    crc_load_o = 1'b0;
    crc_upd_o  = 1'b0;

    unique case (ph_q)
      PH_IDLE: begin
        if (pl_valid_i) begin
          ph_n   = PH_REQ;
          word_n = P_XRDY;
        end
      end
      PH_REQ: begin
        if (evt_i.rrdy) begin
          ph_n       = PH_SOF;
          word_n     = P_SOF;
          scr_load_o = 1'b1;
          crc_load_o = 1'b1;
          tail_n     = 1'b0;
          tail_en    = 1'b1;
        end else begin
          word_n = P_XRDY;
        end
      end
      PH_SOF, PH_BODY: begin
        if (evt_i.hold) begin
          ph_n   = PH_BODY;
          word_n = P_HOLDA;
        end else if (tail_q) begin
          ph_n       = PH_CHK;
          word_n     = crc_i ^ key_i;
          kf_n       = K_DATA;
          scr_step_o = 1'b1;
        end else if (pl_valid_i) begin
          ph_n       = PH_BODY;
          word_n     = pl_data_i ^ key_i;
          kf_n       = K_DATA;
          scr_step_o = 1'b1;
          crc_upd_o  = 1'b1;
          tail_n     = pl_last_i;
          tail_en    = 1'b1;
        end else begin
          ph_n   = PH_BODY;
          word_n = P_HOLD;
        end
      end
      PH_CHK: begin
        ph_n   = PH_EOF;
        word_n = P_EOF;
      end
      PH_EOF: begin
        ph_n   = PH_TERM;
        word_n = P_WTRM;
      end
      PH_TERM: begin
        if (evt_i.rok || evt_i.rerr) begin
          ph_n   = PH_IDLE;
          word_n = P_SYNC;
          done_n = 1'b1;
          ok_n   = evt_i.rok;
          err_n  = evt_i.rerr;
        end else begin
          word_n = P_WTRM;
        end
      end
      default: begin
        ph_n = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      word_q <= P_SYNC;
      kf_q   <= K_PRIM;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      word_q <= word_n;
      kf_q   <= kf_n;
      done_q <= done_n;
      ok_q   <= ok_n;
      err_q  <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= 1'b0;
    end else if (tail_en) begin
      tail_q <= tail_n;
    end
  end

  assign tx_data_o  = word_q;
  assign tx_kflag_o = kf_q;
  assign done_o     = done_q;
  assign ok_o       = ok_q;
  assign err_o      = err_q;

endmodule

// File: rtl/link_tx_framer.sv
module link_tx_framer
  import txs_pkg::*;
#(
  parameter int unsigned         LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]   SCR_SEED  = 16'hFFFF,
  parameter logic [LFSR_W-1:0]   SCR_TAPS  = 16'hD008,
  parameter logic [WORD_W-1:0]   CRC_POLY  = 32'h04C11DB7,
  parameter logic [WORD_W-1:0]   CRC_INIT  = 32'h52325032,
  parameter int unsigned         RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       pl_data_i,
  input  logic              pl_valid_i,
  input  logic              pl_last_i,
  output logic              pl_ready_o,
  input  logic [31:0]       rx_data_i,
  input  logic [3:0]        rx_kflag_i,
  output logic [31:0]       tx_data_o,
  output logic [3:0]        tx_kflag_o,
  output logic              frm_done_o,
  output logic              frm_ok_o,
  output logic              frm_err_o
);

  localparam int unsigned SYNC_MSB = RST_STAGES - 1;

  logic [SYNC_MSB:0] rst_pipe_q;
  logic              rst_core_n;

  // asynchronous assert, synchronous release
  generate
    if (RST_STAGES == 1) begin : g_rs1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe_q <= '0;
        else        rst_pipe_q <= 1'b1;
      end
    end else begin : g_rsn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe_q <= '0;
        else        rst_pipe_q <= {rst_pipe_q[SYNC_MSB-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_core_n = rst_pipe_q[SYNC_MSB];

  rx_evt_t           evt;
  logic [WORD_W-1:0] key;
  logic [WORD_W-1:0] crc;
  logic              scr_load, scr_step, crc_load, crc_upd;

  txs_rxdec u_rxdec (
    .rx_data_i  (rx_data_i),
    .rx_kflag_i (rx_kflag_i),
    .evt_o      (evt)
  );

  txs_scrambler #(
    .WORD_W (WORD_W),
    .LFSR_W (LFSR_W),
    .SEED   (SCR_SEED),
    .TAPS   (SCR_TAPS)
  ) u_scr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (scr_load),
    .step_i (scr_step),
    .key_o  (key)
  );

  txs_crc #(
    .WORD_W (WORD_W),
    .CRC_W  (WORD_W),
    .POLY   (CRC_POLY),
    .INIT   (CRC_INIT)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (crc_load),
    .upd_i  (crc_upd),
    .data_i (pl_data_i),
    .crc_o  (crc)
  );

  txs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .evt_i      (evt),
    .pl_data_i  (pl_data_i),
    .pl_valid_i (pl_valid_i),
    .pl_last_i  (pl_last_i),
    .pl_ready_o (pl_ready_o),
    .key_i      (key),
    .crc_i      (crc),
    .scr_load_o (scr_load),
    .scr_step_o (scr_step),
    .crc_load_o (crc_load),
    .crc_upd_o  (crc_upd),
    .tx_data_o  (tx_data_o),
    .tx_kflag_o (tx_kflag_o),
    .done_o     (frm_done_o),
    .ok_o       (frm_ok_o),
    .err_o      (frm_err_o)
  );

endmodule

// File: rtl/link_tx_framer_chk.sv
module link_tx_framer_chk
  import txs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rx_data,
  input logic [3:0]  rx_kflag,
  input logic        pl_ready,
  input logic [31:0] tx_data,
  input logic [3:0]  tx_kflag,
  input logic        done,
  input logic        ok,
  input logic        err
);

  logic rx_hold, rx_ok, tx_sof, tx_eof, tx_wtrm, tx_sync;

  always_comb begin
    rx_hold = (rx_kflag == K_PRIM) && (rx_data == P_HOLD);
    rx_ok   = (rx_kflag == K_PRIM) && (rx_data == P_ROK);
    tx_sof  = (tx_kflag == K_PRIM) && (tx_data == P_SOF);
    tx_eof  = (tx_kflag == K_PRIM) && (tx_data == P_EOF);
    tx_wtrm = (tx_kflag == K_PRIM) && (tx_data == P_WTRM);
    tx_sync = (tx_kflag == K_PRIM) && (tx_data == P_SYNC);
  end

  p_kflag_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_kflag == K_DATA) || (tx_kflag == K_PRIM));

  p_sof_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |=> !tx_sof);

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hold |-> !pl_ready);

  p_eof_then_wtrm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eof |=> tx_wtrm);

  p_done_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tx_sync && $past(tx_wtrm)));

  p_verdict_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({ok, err}));

  p_no_stray_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(ok || err));

  p_ok_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> $past(rx_ok));

endmodule

bind link_tx_framer link_tx_framer_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_data  (rx_data_i),
  .rx_kflag (rx_kflag_i),
  .pl_ready (pl_ready_o),
  .tx_data  (tx_data_o),
  .tx_kflag (tx_kflag_o),
  .done     (frm_done_o),
  .ok       (frm_ok_o),
  .err      (frm_err_o)
);

// File: tb/link_tx_framer_tb_top.sv
`timescale 1ns/1ps
module link_tx_framer_tb_top;

  localparam logic [31:0] SYNC  = 32'hB5B5957C;
  localparam logic [31:0] XRDY  = 32'h5757B57C;
  localparam logic [31:0] RRDY  = 32'h4A4A957C;
  localparam logic [31:0] SOF   = 32'h3737B57C;
  localparam logic [31:0] EOF   = 32'hD5D5B57C;
  localparam logic [31:0] HOLD  = 32'hD5D5AA7C;
  localparam logic [31:0] HOLDA = 32'h9595AA7C;
  localparam logic [31:0] ROK   = 32'h3535B57C;
  localparam logic [31:0] RERR  = 32'h5656B57C;
  localparam logic [31:0] WTRM  = 32'h5858B57C;
  localparam logic [31:0] RIP   = 32'h5555B57C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pl_data;
  logic        pl_valid;
  logic        pl_last;
  logic        pl_ready;
  logic [31:0] rx_data;
  logic [3:0]  rx_kflag;
  logic [31:0] tx_data;
  logic [3:0]  tx_kflag;
  logic        frm_done, frm_ok, frm_err;

  always #4 clk = ~clk;

  link_tx_framer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pl_data_i  (pl_data),
    .pl_valid_i (pl_valid),
    .pl_last_i  (pl_last),
    .pl_ready_o (pl_ready),
    .rx_data_i  (rx_data),
    .rx_kflag_i (rx_kflag),
    .tx_data_o  (tx_data),
    .tx_kflag_o (tx_kflag),
    .frm_done_o (frm_done),
    .frm_ok_o   (frm_ok),
    .frm_err_o  (frm_err)
  );

  int total = 0;
  int bad   = 0;

  // reference model state
  int          mph;
  bit          mtail;
  logic [15:0] mlfsr;
  logic [31:0] mcrc;
  logic [31:0] e_w;
  logic [3:0]  e_k;
  logic        e_done, e_ok, e_err;
  string       e_tag;

  logic [31:0] fr [16];
  int          flen;
  int          fidx;

  function automatic logic [31:0] b_crc(logic [31:0] c, logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 31; b >= 0; b--) begin
      if (r[31] ^ d[b]) r = (r << 1) ^ 32'h04C11DB7;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [47:0] b_key(logic [15:0] s);
    logic [31:0] k;
    logic [15:0] t = s;
    for (int i = 0; i < 32; i++) begin
      k[i] = t[15];
      t = {t[14:0], t[15] ^ t[14] ^ t[12] ^ t[3]};
    end
    return {t, k};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic new_frame();
    flen = $urandom_range(1, 12);
    for (int i = 0; i < 16; i++) fr[i] = $urandom;
    fidx = 0;
  endtask

  // one clock: compare, drive, predict, advance
  task automatic cyc(logic [31:0] rw, logic [3:0] rk, bit v, string tag_over);
    bit          hold, rrdy, rok, rerr, exp_rdy, take;
    logic [47:0] kr;
    string       tg;
    chk(e_tag, tx_data, e_w);
    chk("R2", {28'd0, tx_kflag}, {28'd0, e_k});
    chk("R9", {29'd0, frm_done, frm_ok, frm_err}, {29'd0, e_done, e_ok, e_err});
    rx_data  = rw;
    rx_kflag = rk;
    pl_valid = v;
    pl_data  = fr[fidx];
    pl_last  = (fidx == flen - 1);
    hold = (rk == 4'b0001) && (rw == HOLD);
    rrdy = (rk == 4'b0001) && (rw == RRDY);
    rok  = (rk == 4'b0001) && (rw == ROK);
    rerr = (rk == 4'b0001) && (rw == RERR);
    exp_rdy = ((mph == 2) || (mph == 3 && !mtail)) && !hold;
    #2;
    chk("R11", {31'd0, pl_ready}, {31'd0, exp_rdy});
    take = 1'b0;
    e_done = 1'b0; e_ok = 1'b0; e_err = 1'b0; e_k = 4'b0001;
    case (mph)
      0: if (v) begin mph = 1; e_w = XRDY; tg = "R3"; end
         else begin e_w = SYNC; tg = "R1"; end
      1: begin
        tg = "R3";
        if (rrdy) begin
          mph = 2; e_w = SOF; mlfsr = 16'hFFFF; mcrc = 32'h52325032; mtail = 1'b0;
        end else e_w = XRDY;
      end
      2, 3: begin
        if (hold) begin mph = 3; e_w = HOLDA; tg = "R4"; end
        else if (mtail) begin
          kr = b_key(mlfsr); e_w = mcrc ^ kr[31:0]; mlfsr = kr[47:32];
          e_k = 4'b0000; mph = 4; tg = "R7";
        end else if (v) begin
          kr = b_key(mlfsr); e_w = fr[fidx] ^ kr[31:0]; mlfsr = kr[47:32];
          mcrc = b_crc(mcrc, fr[fidx]); mtail = (fidx == flen - 1);
          e_k = 4'b0000; mph = 3; tg = "R6"; take = 1'b1;
        end else begin e_w = HOLD; mph = 3; tg = "R5"; end
      end
      4: begin e_w = EOF; mph = 5; tg = "R8"; end
      5: begin e_w = WTRM; mph = 6; tg = "R8"; end
      default: begin
        if (rok || rerr) begin
          e_w = SYNC; e_done = 1'b1; e_ok = rok; e_err = rerr; mph = 0; tg = "R9";
        end else begin e_w = WTRM; tg = "R8"; end
      end
    endcase
    e_tag = (tag_over != "") ? tag_over : tg;
    if (take) begin
      fidx++;
      if (fidx == flen) new_frame();
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rw;
    logic [3:0]  rk;
    void'($urandom(32'd4242));
    rst_n = 1'b0; pl_valid = 1'b0; pl_last = 1'b0; pl_data = '0;
    rx_data = SYNC; rx_kflag = 4'b0001;
    mph = 0; mtail = 1'b0; mlfsr = 16'hFFFF; mcrc = 32'h52325032;
    e_w = SYNC; e_k = 4'b0001; e_done = 1'b0; e_ok = 1'b0; e_err = 1'b0; e_tag = "R1";
    repeat (3) @(posedge clk);
    #1;
    chk("R1", tx_data, SYNC);  // reset state
    chk("R2", {28'd0, tx_kflag}, 32'd1);
    chk("R9", {29'd0, frm_done, frm_ok, frm_err}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // directed: single-dword frame with stalls on last dword and on CRC
    flen = 1; fidx = 0; fr[0] = 32'h12345678;
    cyc(SYNC, 4'b0001, 1'b0, "R1");
    cyc(RRDY, 4'b0001, 1'b0, "R10");  // R_RDY while idle: ignored
    cyc(SYNC, 4'b0001, 1'b1, "R10");
    cyc(ROK,  4'b0001, 1'b1, "");      // verdict during request: ignored
    cyc(RRDY, 4'b0000, 1'b1, "R10");  // not a primitive
    cyc(RRDY, 4'b0010, 1'b1, "R10");  // wrong lane
    cyc(RRDY, 4'b0001, 1'b1, "R10");
    cyc(HOLD, 4'b0001, 1'b1, "R3");   // SOF visible; hold vs last dword
    cyc(HOLD, 4'b0000, 1'b1, "R4");   // HOLD as data: not a stall
    cyc(HOLD, 4'b0001, 1'b0, "R6");   // hold vs CRC launch
    cyc(SYNC, 4'b0001, 1'b0, "R4");
    cyc(SYNC, 4'b0001, 1'b0, "R7");
    cyc(RRDY, 4'b0001, 1'b0, "R8");
    cyc(RERR, 4'b0001, 1'b0, "R8");
    cyc(SYNC, 4'b0001, 1'b0, "R9");
    cyc(SYNC, 4'b0001, 1'b0, "R1");

    // random run
    new_frame();
    for (int n = 0; n < 4000; n++) begin
      rk = 4'b0001;
      case ($urandom_range(0, 8))
        0: rw = SYNC;
        1: rw = RIP;
        2: rw = RRDY;
        3: rw = HOLD;
        4: rw = ROK;
        5: rw = RERR;
        6: begin rw = HOLD; rk = 4'b0000; end
        7: begin rw = RRDY; rk = 4'b1000; end
        default: rw = $urandom;
      endcase
      cyc(rw, rk, ($urandom_range(0, 3) != 0), "");
    end
    cyc(SYNC, 4'b0001, 1'b0, "");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule